// File: doc/BRIEF.md
# NAND Flash Instruction Sequencer

This block drives one raw 8-bit NAND flash device through a short program of up to eight 4-bit opcode slots. The host sets up the opcode list, four command bytes, a block and page address, a column, a spare-area select, a byte count and a 32-bit user data word. A one-cycle `start` pulse then launches the operation. The sequencer walks the slots from slot 0 upward. For each slot it produces command latch cycles, address latch cycles, ready waits, data transfers or a status read. Data moves between the flash and an external page buffer port, one byte per strobe.

Each byte on the flash bus takes two clocks. In the first clock the write strobe or the read strobe is low. In the second clock it is high again and the data stays on the bus. Read data is captured at the clock edge that ends the low-strobe clock. A wait slot polls the ready/busy line after a short settle time. If the line stays low past a programmable limit, the run is aborted and a timeout flag is raised in place of the completion flag. A separate sticky register keeps per-subpage corrected and uncorrectable ECC events, which arrive as input pulses from an external engine.

Top module: `nand_seq`

## Requirements
- R1: After reset the block is idle: `busy`=0, `nf_ce_n`=1, `nf_we_n`=1, `nf_re_n`=1, `nf_cle`=0, `nf_ale`=0, both event flags are 0 and `ecc_status` is 0.
- R2: Slot n sits in `instr[4n+3:4n]`. Slots run in ascending order from slot 0. Code 0 (and any code 12..15) ends the run with completion. If no slot ends early, all eight slots run.
- R3: Codes 1..4 each send one command byte with CLE high. Code k+1 sends `cmd_bytes[8k+7:8k]`.
- R4: Code 6 sends the row address LSB first with ALE high, in 2+`addr_len` cycles. In large-page mode the row is {block, page_idx[5:0]}. In small-page mode it is {block, page_idx[4:0]}.
- R5: Code 5 sends the column with ALE high. The effective column is `column`, plus 2048 (large page) or 512 (small page) when `spare_sel`=1. Large-page mode uses two cycles, LSB first. Small-page mode uses one cycle carrying the low byte.
- R6: A transfer length of `byte_count`=0 means 2112 bytes in large-page mode and 528 bytes in small-page mode. Any other value means exactly that many bytes.
- R7: Code 8 waits for ready, then reads the transfer length into the buffer starting at the effective column. Code 9 writes buffer bytes from the effective column onward to the flash with CLE and ALE low.
- R8: Code 7 sends `user_data[7:0]` as one ALE cycle. Code 10 waits for ready and then sends command byte 1. Code 11 reads one byte into `data_reg_o[7:0]`, and the upper bits keep `user_data`.
- R9: A normal end sets `evt_done`. Each start clears both flags. The two flags are never high together.
- R10: If a wait slot sees ready low for (`wait_tmo`+1)·16 cycles, the run stops, sends nothing more, and sets `evt_tmo` but not `evt_done`.
- R11: Corrected events for lanes 0..3 set `ecc_status` bits 12..15, and uncorrectable events set bits 28..31. Writing 1s through `ecc_clr_mask` clears those bits. In small-page mode only lane 0 (bits 12 and 28) records events.
- R12: CLE and ALE are never high together, the data bus is never driven while the read strobe is low, and both strobes stay high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, ignored while busy |
| instr | input | 32 | Eight 4-bit opcode slots |
| cmd_bytes | input | 32 | Command bytes 0..3 |
| block_addr | input | 20 | Block part of the row address |
| page_idx | input | 6 | Page within the block |
| spare_sel | input | 1 | Column addresses the spare area |
| column | input | 12 | Column offset |
| byte_count | input | 12 | Transfer length, 0 = page plus spare |
| user_data | input | 32 | User data word loaded at start |
| large_page | input | 1 | 1 = 2048-byte pages, 0 = 512-byte pages |
| addr_len | input | 2 | Extra row-address cycles (0..2) |
| wait_tmo | input | 4 | Ready-wait limit selector |
| busy | output | 1 | Run in progress |
| evt_done | output | 1 | Sticky normal completion |
| evt_tmo | output | 1 | Sticky ready-wait timeout |
| data_reg_o | output | 32 | Data word with status byte |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Flash data out |
| nf_dq_oe | output | 1 | Flash data output enable |
| nf_dq_i | input | 8 | Flash data in |
| nf_rb_n | input | 1 | Ready/busy, low = busy |
| buf_addr | output | 12 | Page buffer address |
| buf_wdata | output | 8 | Page buffer write data |
| buf_we | output | 1 | Page buffer write enable |
| buf_rdata | input | 8 | Page buffer read data |
| ecc_corr_set | input | 4 | Per-lane corrected-error event pulses |
| ecc_unc_set | input | 4 | Per-lane uncorrectable event pulses |
| ecc_clr_we | input | 1 | Apply the clear mask |
| ecc_clr_mask | input | 32 | Write-1-to-clear mask |
| ecc_status | output | 32 | Sticky ECC status |

## Verification
The hardest condition to reach from the ports is a wait slot that is still holding the bus in the middle of a program, with later slots pending. The bench holds ready low from the start of an erase program and checks that only the bytes before the wait slot have appeared after many cycles. It then releases ready and checks that the delayed command and the status read follow. Timeout is reached by keeping ready low with the shortest and the longest limit selector, and the bench counts the busy cycles against the expected window.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
  localparam logic [3:0] OP_NOP = 4'd0;
  localparam logic [3:0] OP_CM0 = 4'd1;
  localparam logic [3:0] OP_CM1 = 4'd2;
  localparam logic [3:0] OP_CM2 = 4'd3;
  localparam logic [3:0] OP_CM3 = 4'd4;
  localparam logic [3:0] OP_CA  = 4'd5;
  localparam logic [3:0] OP_PA  = 4'd6;
  localparam logic [3:0] OP_UA  = 4'd7;
  localparam logic [3:0] OP_RBW = 4'd8;
  localparam logic [3:0] OP_WB  = 4'd9;
  localparam logic [3:0] OP_CW1 = 4'd10;
  localparam logic [3:0] OP_RS  = 4'd11;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_FETCH = 3'd1,
    S_WAIT  = 3'd2,
    S_STRB  = 3'd3,
    S_HOLD  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/nfs_addr.sv
module nfs_addr #(
  parameter int BLK_W     = 20,
  parameter int COL_W     = 12,
  parameter int CNT_W     = 12,
  parameter int PG_LARGE  = 2048,
  parameter int SPR_LARGE = 64,
  parameter int PG_SMALL  = 512,
  parameter int SPR_SMALL = 16
) (
  input  logic             large_page,
  input  logic             spare_sel,
  input  logic [COL_W-1:0] column,
  input  logic [BLK_W-1:0] block_addr,
  input  logic [5:0]       page_idx,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [1:0]       addr_len,
  output logic [COL_W-1:0] col_eff,
  output logic [31:0]      row,
  output logic [2:0]       col_cycles,
  output logic [2:0]       row_cycles,
  output logic [CNT_W-1:0] xfer_len
);
  localparam logic [COL_W-1:0] SPR_OFS_L = COL_W'(PG_LARGE);
  localparam logic [COL_W-1:0] SPR_OFS_S = COL_W'(PG_SMALL);
  localparam logic [CNT_W-1:0] FULL_L    = CNT_W'(PG_LARGE + SPR_LARGE);
  localparam logic [CNT_W-1:0] FULL_S    = CNT_W'(PG_SMALL + SPR_SMALL);

  always_comb begin
    col_eff    = column + (spare_sel ? (large_page ? SPR_OFS_L : SPR_OFS_S) : '0);
    row        = large_page ? 32'({block_addr, page_idx}) : 32'({block_addr, page_idx[4:0]});
    col_cycles = large_page ? 3'd2 : 3'd1;
    row_cycles = 3'd2 + ((addr_len == 2'd3) ? 3'd2 : {1'b0, addr_len});
    xfer_len   = (byte_count == '0) ? (large_page ? FULL_L : FULL_S) : byte_count;
  end
endmodule

// File: rtl/nfs_wait_timer.sv
module nfs_wait_timer #(
  parameter int TMO_SHIFT = 4,
  parameter int SETTLE    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] tmo_sel,
  input  logic       rb_n,
  output logic       ready_ok,
  output logic       expired
);
  localparam int CW = TMO_SHIFT + 6;

  logic [CW-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit    = CW'({1'b0, tmo_sel} + 5'd1) << TMO_SHIFT;
    ready_ok = run && (cnt_q >= CW'(SETTLE)) && rb_n;
    expired  = run && !ready_ok && (cnt_q >= limit);
    if (!run)                cnt_d = '0;
    else if (cnt_q >= limit) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nfs_ecc_stat.sv
module nfs_ecc_stat #(
  parameter int LANES    = 4,
  parameter int CORR_LSB = 12,
  parameter int UNC_LSB  = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             small_page,
  input  logic [LANES-1:0] corr_set,
  input  logic [LANES-1:0] unc_set,
  input  logic             clr_we,
  input  logic [31:0]      clr_mask,
  output logic [31:0]      status
);
  logic [LANES-1:0] lane_en, corr_q, unc_q, corr_d, unc_d, corr_clr, unc_clr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_en[g] = (g == 0) | ~small_page;
  end

  always_comb begin
    corr_clr = clr_we ? clr_mask[CORR_LSB +: LANES] : '0;
    unc_clr  = clr_we ? clr_mask[UNC_LSB +: LANES]  : '0;
    corr_d   = (corr_q & ~corr_clr) | (corr_set & lane_en);
    unc_d    = (unc_q & ~unc_clr) | (unc_set & lane_en);
    status   = '0;
    status[CORR_LSB +: LANES] = corr_q;
    status[UNC_LSB +: LANES]  = unc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_q <= '0;
      unc_q  <= '0;
    end else begin
      corr_q <= corr_d;
      unc_q  <= unc_d;
    end
  end
endmodule

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int NSLOT     = 8,
  parameter int BLK_W     = 20,
  parameter int COL_W     = 12,
  parameter int CNT_W     = 12,
  parameter int TMO_SHIFT = 4,
  parameter int SETTLE    = 2,
  parameter int LANES     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [4*NSLOT-1:0] instr,
  input  logic [31:0]        cmd_bytes,
  input  logic [BLK_W-1:0]   block_addr,
  input  logic [5:0]         page_idx,
  input  logic               spare_sel,
  input  logic [COL_W-1:0]   column,
  input  logic [CNT_W-1:0]   byte_count,
  input  logic [31:0]        user_data,
  input  logic               large_page,
  input  logic [1:0]         addr_len,
  input  logic [3:0]         wait_tmo,
  output logic               busy,
  output logic               evt_done,
  output logic               evt_tmo,
  output logic [31:0]        data_reg_o,
  output logic               nf_ce_n,
  output logic               nf_cle,
  output logic               nf_ale,
  output logic               nf_we_n,
  output logic               nf_re_n,
  output logic [7:0]         nf_dq_o,
  output logic               nf_dq_oe,
  input  logic [7:0]         nf_dq_i,
  input  logic               nf_rb_n,
  output logic [COL_W-1:0]   buf_addr,
  output logic [7:0]         buf_wdata,
  output logic               buf_we,
  input  logic [7:0]         buf_rdata,
  input  logic [LANES-1:0]   ecc_corr_set,
  input  logic [LANES-1:0]   ecc_unc_set,
  input  logic               ecc_clr_we,
  input  logic [31:0]        ecc_clr_mask,
  output logic [31:0]        ecc_status
);
  import nfs_pkg::*;
  localparam int SLOT_W = $clog2(NSLOT);

  seq_state_e       state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [CNT_W-1:0] bidx_q, bidx_d, nbytes;
  logic [COL_W-1:0] ptr_q, ptr_d, col_eff;
  logic [31:0]      data_q, data_d, row;
  logic             done_q, done_d, tmo_q, tmo_d;
  logic [2:0]       col_cycles, row_cycles;
  logic [CNT_W-1:0] xfer_len;
  logic [3:0]       op;
  logic [1:0]       cidx;
  logic             is_cmd, is_addr, is_read, is_wait, is_data, is_end, on_bus, last_byte;
  logic             ready_ok, expired;
  logic [15:0]      col16;

  nfs_addr #(.BLK_W(BLK_W), .COL_W(COL_W), .CNT_W(CNT_W)) u_addr (
    .large_page(large_page), .spare_sel(spare_sel), .column(column),
    .block_addr(block_addr), .page_idx(page_idx), .byte_count(byte_count),
    .addr_len(addr_len), .col_eff(col_eff), .row(row),
    .col_cycles(col_cycles), .row_cycles(row_cycles), .xfer_len(xfer_len)
  );

  nfs_wait_timer #(.TMO_SHIFT(TMO_SHIFT), .SETTLE(SETTLE)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q == S_WAIT), .tmo_sel(wait_tmo),
    .rb_n(nf_rb_n), .ready_ok(ready_ok), .expired(expired)
  );

  nfs_ecc_stat #(.LANES(LANES)) u_ecc (
    .clk(clk), .rst_n(rst_n), .small_page(~large_page), .corr_set(ecc_corr_set),
    .unc_set(ecc_unc_set), .clr_we(ecc_clr_we), .clr_mask(ecc_clr_mask),
    .status(ecc_status)
  );

  // Opcode decode for the current slot
  always_comb begin
    op      = instr[{slot_q, 2'b00} +: 4];
    is_cmd  = (op >= OP_CM0 && op <= OP_CM3) || op == OP_CW1;
    is_addr = op == OP_CA || op == OP_PA || op == OP_UA;
    is_read = op == OP_RBW || op == OP_RS;
    is_wait = op == OP_RBW || op == OP_CW1;
    is_data = op == OP_RBW || op == OP_WB;
    is_end  = op == OP_NOP || op > OP_RS;
    cidx    = (op == OP_CW1) ? 2'd1 : 2'(op - OP_CM0);
    case (op)
      OP_CA:          nbytes = CNT_W'(col_cycles);
      OP_PA:          nbytes = CNT_W'(row_cycles);
      OP_RBW, OP_WB:  nbytes = xfer_len;
      default:        nbytes = CNT_W'(1);
    endcase
    last_byte = (bidx_q == nbytes - 1'b1);
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    bidx_d  = bidx_q;
    ptr_d   = ptr_q;
    data_d  = data_q;
    done_d  = done_q;
    tmo_d   = tmo_q;
    case (state_q)
      S_IDLE: if (start) begin
        state_d = S_FETCH;
        slot_d  = '0;
        ptr_d   = col_eff;
        data_d  = user_data;
        done_d  = 1'b0;
        tmo_d   = 1'b0;
      end
      S_FETCH: begin
        bidx_d = '0;
        if (is_end) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else if (is_wait) state_d = S_WAIT;
        else                  state_d = S_STRB;
      end
      S_WAIT: begin
        if (ready_ok) state_d = S_STRB;
        else if (expired) begin
          state_d = S_IDLE;
          tmo_d   = 1'b1;
        end
      end
      S_STRB: begin
        if (op == OP_RS) data_d[7:0] = nf_dq_i;
        state_d = S_HOLD;
      end
      default: begin
        if (is_data) ptr_d = ptr_q + 1'b1;
        if (!last_byte) begin
          bidx_d  = bidx_q + 1'b1;
          state_d = S_STRB;
        end else if (slot_q == SLOT_W'(NSLOT - 1)) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else begin
          slot_d  = slot_q + 1'b1;
          state_d = S_FETCH;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      slot_q  <= '0;
      bidx_q  <= '0;
      ptr_q   <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      bidx_q  <= bidx_d;
      ptr_q   <= ptr_d;
      data_q  <= data_d;
      done_q  <= done_d;
      tmo_q   <= tmo_d;
    end
  end

  // Flash pins and buffer port
  always_comb begin
    on_bus     = (state_q == S_STRB) || (state_q == S_HOLD);
    busy       = state_q != S_IDLE;
    nf_ce_n    = ~busy;
    nf_cle     = on_bus && is_cmd;
    nf_ale     = on_bus && is_addr;
    nf_we_n    = ~((state_q == S_STRB) && !is_read);
    nf_re_n    = ~((state_q == S_STRB) && is_read);
    nf_dq_oe   = on_bus && !is_read;
    col16      = 16'(col_eff);
    case (op)
      OP_CA:   nf_dq_o = col16[{bidx_q[0], 3'b000} +: 8];
      OP_PA:   nf_dq_o = row[{bidx_q[1:0], 3'b000} +: 8];
      OP_UA:   nf_dq_o = data_q[7:0];
      OP_WB:   nf_dq_o = buf_rdata;
      default: nf_dq_o = is_cmd ? cmd_bytes[{cidx, 3'b000} +: 8] : 8'h00;
    endcase
    buf_addr   = ptr_q;
    buf_wdata  = nf_dq_i;
    buf_we     = (state_q == S_STRB) && (op == OP_RBW);
    evt_done   = done_q;
    evt_tmo    = tmo_q;
    data_reg_o = data_q;
  end
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic evt_done,
  input logic evt_tmo,
  input logic nf_cle,
  input logic nf_ale,
  input logic nf_we_n,
  input logic nf_re_n,
  input logic nf_dq_oe,
  input logic buf_we
);
  a_r12_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));

  a_r12_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_re_n |-> !nf_dq_oe);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nf_we_n && nf_re_n && !nf_cle && !nf_ale));

  a_r9_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_done && evt_tmo));

  a_r9_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (evt_done ^ evt_tmo));

  a_r7_buf_wr_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (!nf_re_n && busy));
endmodule

bind nand_seq nand_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .evt_done(evt_done), .evt_tmo(evt_tmo),
  .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
  .nf_dq_oe(nf_dq_oe), .buf_we(buf_we)
);

// File: tb/tb_nand_seq.sv
`timescale 1ns/1ps
module tb_nand_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] instr, cmd_bytes, user_data;
  logic [19:0] block_addr;
  logic [5:0]  page_idx;
  logic        spare_sel, large_page;
  logic [11:0] column, byte_count;
  logic [1:0]  addr_len;
  logic [3:0]  wait_tmo;
  logic        busy, evt_done, evt_tmo;
  logic [31:0] data_reg_o;
  logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [7:0]  nf_dq_o, nf_dq_i;
  logic        nf_rb_n;
  logic [11:0] buf_addr;
  logic [7:0]  buf_wdata, buf_rdata;
  logic        buf_we;
  logic [3:0]  ecc_corr_set, ecc_unc_set;
  logic        ecc_clr_we;
  logic [31:0] ecc_clr_mask, ecc_status;

  always #10 clk = ~clk;

  nand_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .cmd_bytes(cmd_bytes),
    .block_addr(block_addr), .page_idx(page_idx), .spare_sel(spare_sel),
    .column(column), .byte_count(byte_count), .user_data(user_data),
    .large_page(large_page), .addr_len(addr_len), .wait_tmo(wait_tmo),
    .busy(busy), .evt_done(evt_done), .evt_tmo(evt_tmo), .data_reg_o(data_reg_o),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i),
    .nf_rb_n(nf_rb_n), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_we(buf_we),
    .buf_rdata(buf_rdata), .ecc_corr_set(ecc_corr_set), .ecc_unc_set(ecc_unc_set),
    .ecc_clr_we(ecc_clr_we), .ecc_clr_mask(ecc_clr_mask), .ecc_status(ecc_status)
  );

  // Flash and buffer models
  logic [7:0] mem [0:4095];
  logic [9:0] lg [0:63];
  integer     lg_n, rd_cnt, wr_cnt;
  logic [7:0] rd_base;
  logic [11:0] last_wr;
  integer     n_chk = 0, n_fail = 0;

  assign buf_rdata = mem[buf_addr];
  assign nf_dq_i   = rd_base + rd_cnt[7:0];

  always @(posedge nf_we_n) if (nf_ce_n === 1'b0 && lg_n < 64) begin
    lg[lg_n] = {nf_cle, nf_ale, nf_dq_o};
    lg_n = lg_n + 1;
  end
  always @(posedge nf_re_n) if (nf_ce_n === 1'b0) rd_cnt = rd_cnt + 1;
  always @(posedge clk) if (buf_we) begin
    mem[buf_addr] <= buf_wdata;
    wr_cnt  <= wr_cnt + 1;
    last_wr <= buf_addr;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr_log();
    lg_n = 0; rd_cnt = 0; wr_cnt = 0;
  endtask

  task automatic run_op(output integer cyc);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 1;
    while (busy && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic setup(input logic [31:0] ins, input logic [31:0] cb, input logic lp);
    instr = ins; cmd_bytes = cb; large_page = lp;
    column = 0; spare_sel = 0; block_addr = 0; page_idx = 0; addr_len = 0;
    byte_count = 0; user_data = 0; wait_tmo = 4'd15; nf_rb_n = 1'b1;
    clr_log();
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 pins", {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale}, 5'b11100);
    chk("R1 flags", {evt_done, evt_tmo}, 0);
    chk("R1 ecc", ecc_status, 0);
  endtask

  task automatic t_large_read();
    integer c;
    setup(32'h0008_2651, 32'h0000_3000, 1'b1);
    block_addr = 20'h123; page_idx = 6'h35; byte_count = 5; rd_base = 8'h40;
    run_op(c);
    chk("R4 R3 R5 count", lg_n, 6);
    chk("R3 cmd0", lg[0], 10'h200);
    chk("R5 col lo", lg[1], 10'h100);
    chk("R5 col hi", lg[2], 10'h100);
    chk("R4 row0 large", lg[3], 10'h1F5);
    chk("R4 row1 large", lg[4], 10'h148);
    chk("R3 cmd1", lg[5], 10'h230);
    chk("R7 R6 reads", wr_cnt, 5);
    chk("R7 data", mem[4], 8'h44);
    chk("R9 done", {evt_done, evt_tmo}, 2'b10);
  endtask

  task automatic t_small_read();
    integer c;
    setup(32'h0000_8651, 32'h0000_0050, 1'b0);
    column = 3; spare_sel = 1; block_addr = 9; page_idx = 6'h27; addr_len = 1;
    byte_count = 3; rd_base = 8'h80;
    run_op(c);
    chk("R5 R4 small count", lg_n, 5);
    chk("R5 small col", lg[1], 10'h103);
    chk("R4 row0 small", lg[2], 10'h127);
    chk("R4 row1 small", lg[3], 10'h101);
    chk("R4 row2 extra", lg[4], 10'h100);
    chk("R7 spare start", last_wr, 12'd517);
    chk("R7 spare data", {mem[515], mem[517]}, 16'h8082);
  endtask

  task automatic t_full();
    integer c;
    setup(32'h0000_8651, 32'h0, 1'b0);
    run_op(c);
    chk("R6 small full", wr_cnt, 528);
    chk("R6 small last", last_wr, 12'd527);
    setup(32'h0008_2651, 32'h0, 1'b1);
    run_op(c);
    chk("R6 large full", wr_cnt, 2112);
    chk("R6 large last", last_wr, 12'd2111);
  endtask

  task automatic t_program();
    integer c;
    setup(32'h0BA4_9653, 32'h1080_7000, 1'b1);
    block_addr = 1; page_idx = 2; byte_count = 4; user_data = 32'h1234_5678;
    rd_base = 8'hE0;
    for (int i = 0; i < 4; i++) mem[i] = 8'hA0 + 8'(i);
    run_op(c);
    chk("R7 R8 prog count", lg_n, 11);
    chk("R3 cmd2", lg[0], 10'h280);
    chk("R4 prog row", lg[3], 10'h142);
    chk("R7 wb first", lg[5], 10'h0A0);
    chk("R7 wb last", lg[8], 10'h0A3);
    chk("R3 cmd3", lg[9], 10'h210);
    chk("R8 cw1 cmd1", lg[10], 10'h270);
    chk("R8 status", data_reg_o, 32'h1234_56E0);
    chk("R7 no buf wr", wr_cnt, 0);
  endtask

  task automatic t_erase_wait();
    setup(32'h000B_A361, 32'h00D0_7060, 1'b1);
    block_addr = 2; addr_len = 1; rd_base = 8'hC5; nf_rb_n = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (60) @(negedge clk);
    chk("R8 held in wait", {busy, 5'(lg_n)}, {1'b1, 5'd5});
    chk("R4 erase row", lg[1], 10'h180);
    chk("R3 erase cmd2", lg[4], 10'h2D0);
    nf_rb_n = 1'b1;
    for (int i = 0; i < 40 && busy; i++) @(negedge clk);
    chk("R8 after ready", lg_n, 6);
    chk("R8 cw1 sent", lg[5], 10'h270);
    chk("R8 erase status", data_reg_o[7:0], 8'hC5);
    chk("R9 erase done", {evt_done, evt_tmo}, 2'b10);
  endtask

  task automatic t_user_addr();
    integer c;
    setup(32'h0000_0871, 32'h0000_0090, 1'b1);
    user_data = 32'h0000_00AB; byte_count = 2; rd_base = 8'h11;
    run_op(c);
    chk("R8 ua count", lg_n, 2);
    chk("R8 ua byte", lg[1], 10'h1AB);
    chk("R7 ua reads", {wr_cnt[7:0], mem[1]}, {8'd2, 8'h12});
  endtask

  task automatic t_timeout();
    integer c;
    setup(32'h0000_000A, 32'h0000_7000, 1'b1);
    nf_rb_n = 1'b0; wait_tmo = 0;
    run_op(c);
    chk("R10 short flags", {evt_done, evt_tmo}, 2'b01);
    chk("R10 no bytes", lg_n, 0);
    chk("R10 short window", (c >= 17 && c <= 19), 1);
    clr_log(); wait_tmo = 4'd15;
    run_op(c);
    chk("R10 long window", (c >= 257 && c <= 259), 1);
    chk("R10 long flags", {evt_done, evt_tmo}, 2'b01);
  endtask

  task automatic t_slots();
    integer c;
    setup(32'h1111_1111, 32'h0000_00FF, 1'b1);
    run_op(c);
    chk("R2 eight slots", lg_n, 8);
    chk("R2 last slot", lg[7], 10'h2FF);
    chk("R9 flag clears", {evt_done, evt_tmo}, 2'b10);
    setup(32'h0000_0101, 32'h0000_00EE, 1'b1);
    run_op(c);
    chk("R2 nop ends", lg_n, 1);
    chk("R2 end done", evt_done, 1);
  endtask

  task automatic t_ecc();
    large_page = 1'b1;
    @(negedge clk) begin ecc_corr_set = 4'b0100; ecc_unc_set = 4'b0010; end
    @(negedge clk) begin ecc_corr_set = 0; ecc_unc_set = 0; end
    chk("R11 lanes", ecc_status, 32'h2000_4000);
    @(negedge clk) begin ecc_clr_we = 1; ecc_clr_mask = 32'h0000_4000; end
    @(negedge clk) ecc_clr_we = 0;
    chk("R11 w1c", ecc_status, 32'h2000_0000);
    large_page = 1'b0;
    @(negedge clk) begin ecc_corr_set = 4'hF; ecc_unc_set = 4'hF; end
    @(negedge clk) begin ecc_corr_set = 0; ecc_unc_set = 0; end
    chk("R11 small lane", ecc_status, 32'h3000_1000);
    @(negedge clk) begin ecc_clr_we = 1; ecc_clr_mask = 32'hFFFF_FFFF; end
    @(negedge clk) ecc_clr_we = 0;
    chk("R11 clear all", ecc_status, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 0; rd_base = 0; ecc_corr_set = 0; ecc_unc_set = 0;
    ecc_clr_we = 0; ecc_clr_mask = 0;
    setup(32'h0, 32'h0, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_large_read();
    t_small_read();
    t_full();
    t_program();
    t_erase_wait();
    t_user_addr();
    t_timeout();
    t_slots();
    t_ecc();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule